// File: doc/BRIEF.md
# Ling Pseudo-Carry Lookahead Adder

This block adds two unsigned binary operands and a carry-in, and returns the sum and a carry-out. It has no registers, so a result is valid once the inputs have settled. Its carry network is built on pseudo-carries rather than ordinary carries. Each bit forms a generate term (AND), a transmit term (OR) and a half-sum (XOR). A pseudo-carry `h` is then derived for every bit position. The true carry into bit i is never formed as a signal of its own. It is only implied as `h[i]` ANDed with the transmit term of bit i-1.

The operand positions are cut into groups of `GROUP` bits. Inside a group, each position's pseudo-carry is a flat sum of products: the group's generate and transmit terms, plus the pseudo-carry entering the group. The pseudo-carry at the top of each group becomes the input of the next group. This makes the group boundaries a short lookahead chain. The chain starts from the carry-in. Each sum bit is chosen from the pseudo-carry: when `h[i]` is 0 the bit is the half-sum, and when `h[i]` is 1 it is the half-sum XORed with the lower transmit term.

Top module: `ling_adder`

## Requirements
- R1: `{carry_out_o, sum_o}` equals `op_a_i + op_b_i + carry_in_i` as an unsigned (WIDTH+1)-bit value, for every input combination.
- R2: With both operands zero, `sum_o` has bit 0 equal to `carry_in_i` and every other bit 0, and `carry_out_o` is 0.
- R3: The carry into bit i (i.e. `sum_o[i] ^ op_a_i[i] ^ op_b_i[i]`) equals the ripple carry of the operands below bit i. Bit 0 receives `carry_in_i`.
- R4: `carry_out_o` is the majority of `op_a_i[WIDTH-1]`, `op_b_i[WIDTH-1]` and the carry into bit WIDTH-1.
- R5: When `op_a_i ^ op_b_i` is all ones, every `sum_o` bit equals the inverse of `carry_in_i` and `carry_out_o` equals `carry_in_i`. The carry-in then travels the full width.
- R6: When both operands are all ones, `carry_out_o` is 1, `sum_o[0]` equals `carry_in_i`, and all other sum bits are 1.
- R7: R1 holds for any WIDTH and GROUP, including a WIDTH that is not a multiple of GROUP. In that case the last group is shorter.
- R8: The outputs are a pure function of the present inputs. A new input vector is reflected at the outputs in the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand |
| carry_in_i | input | 1 | Carry into bit 0; it seeds the pseudo-carry chain |
| sum_o | output | WIDTH | Sum bits |
| carry_out_o | output | 1 | Carry out of the top bit |

## Verification
The assertions are immediate checks evaluated whenever the inputs change. They assume the operands and carry-in are known 0/1 values and have settled, since an X on an input would spread through every pseudo-carry product. The bench drives all inputs from a task one time unit after a clock edge. It samples results half a period later, so each check sees a settled vector and no X values. The 8-bit instance with three-bit groups is driven exhaustively, which covers the short last group. The 16-bit instance receives fixed propagate and generate patterns and then pseudo-random vectors.

// File: rtl/ling_pkg.sv
package ling_pkg;
    typedef struct packed {
        logic gen;   // x & y
        logic xmit;  // x | y
        logic half;  // x ^ y
    } ling_bit_t;
endpackage

// File: rtl/ling_bit_terms.sv
module ling_bit_terms #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]                 a_i,
    input  logic [WIDTH-1:0]                 b_i,
    output ling_pkg::ling_bit_t [WIDTH-1:0]  terms_o,
    output logic [WIDTH:0]                   xmit_ext_o
);
    // xmit_ext_o[i] is the transmit term of bit i-1; position 0 reads as 1
    assign xmit_ext_o[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign terms_o[i].gen  = a_i[i] & b_i[i];
        assign terms_o[i].xmit = a_i[i] | b_i[i];
        assign terms_o[i].half = a_i[i] ^ b_i[i];
        assign xmit_ext_o[i+1] = a_i[i] | b_i[i];
    end
endmodule

// File: rtl/ling_group.sv
module ling_group #(
    parameter int WIDTH = 16,
    parameter int BASE  = 0,
    parameter int SIZE  = 4
) (
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH:0]   xmit_ext_i,
    input  logic             h_in_i,
    output logic [SIZE:1]    h_o
);
    // h[BASE+k] = OR over m of g[BASE+m] * t[BASE+m .. BASE+k-2]
    //           + t[BASE-1 .. BASE+k-2] * h[BASE]
    always_comb begin
        for (int k = 1; k <= SIZE; k++) begin
            logic acc;
            logic prod_t;
            acc    = 1'b0;
            prod_t = 1'b1;
            for (int m = k - 1; m >= 0; m--) begin
                acc    = acc | (gen_i[BASE+m] & prod_t);
                prod_t = prod_t & xmit_ext_i[BASE+m];
            end
            h_o[k] = acc | (prod_t & h_in_i);
        end
    end
endmodule

// File: rtl/ling_sum_select.sv
module ling_sum_select #(
    parameter int WIDTH = 16
) (
    input  ling_pkg::ling_bit_t [WIDTH-1:0] terms_i,
    input  logic [WIDTH-1:0]                h_i,
    input  logic [WIDTH:0]                  xmit_ext_i,
    output logic [WIDTH-1:0]                sum_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
        assign sum_o[i] = h_i[i] ? (terms_i[i].half ^ xmit_ext_i[i])
                                 : terms_i[i].half;
    end
endmodule

// File: rtl/ling_adder.sv
module ling_adder #(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic             carry_in_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_out_o
);
    localparam int NGROUPS = (WIDTH + GROUP - 1) / GROUP;
    localparam int LAST_SZ = WIDTH - (NGROUPS - 1) * GROUP;

    ling_pkg::ling_bit_t [WIDTH-1:0] terms;
    logic [WIDTH:0]   xmit_ext;
    logic [WIDTH-1:0] gen_vec;
    logic [WIDTH:0]   h;

    ling_bit_terms #(.WIDTH(WIDTH)) terms_i (
        .a_i        (op_a_i),
        .b_i        (op_b_i),
        .terms_o    (terms),
        .xmit_ext_o (xmit_ext)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_gen
        assign gen_vec[i] = terms[i].gen;
    end

    assign h[0] = carry_in_i;

    for (genvar gi = 0; gi < NGROUPS; gi++) begin : g_grp
        localparam int BASE = gi * GROUP;
        localparam int SZ   = (gi == NGROUPS - 1) ? LAST_SZ : GROUP;
        logic [SZ:1] h_grp;

        ling_group #(.WIDTH(WIDTH), .BASE(BASE), .SIZE(SZ)) grp_i (
            .gen_i      (gen_vec),
            .xmit_ext_i (xmit_ext),
            .h_in_i     (h[BASE]),
            .h_o        (h_grp)
        );
        assign h[BASE+SZ:BASE+1] = h_grp;
    end

    ling_sum_select #(.WIDTH(WIDTH)) sel_i (
        .terms_i    (terms),
        .h_i        (h[WIDTH-1:0]),
        .xmit_ext_i (xmit_ext),
        .sum_o      (sum_o)
    );

    assign carry_out_o = h[WIDTH] & xmit_ext[WIDTH];
endmodule

// File: rtl/ling_adder_chk.sv
module ling_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_i,
    input logic             cout_i,
    input logic [WIDTH:0]   h_i,
    input logic [WIDTH:0]   xmit_ext_i
);
    logic [WIDTH:0] ref_total;
    logic [WIDTH:0] carry_in_bits;
    logic           top_carry;

    always_comb begin
        ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        carry_in_bits = {1'b0, sum_i ^ a_i ^ b_i};
        top_carry = carry_in_bits[WIDTH-1];
        if (!$isunknown({a_i, b_i, cin_i})) begin
            a_r1_total_matches: assert ({cout_i, sum_i} == ref_total);
            a_r2_zero_operands: assert (!((a_i == '0) && (b_i == '0)) ||
                ({cout_i, sum_i} == {{WIDTH{1'b0}}, cin_i}));
            a_r4_carry_out_majority: assert (cout_i ==
                ((a_i[WIDTH-1] & b_i[WIDTH-1]) |
                 (top_carry & (a_i[WIDTH-1] ^ b_i[WIDTH-1]))));
            a_r5_full_propagate: assert (!((a_i ^ b_i) == '1) ||
                ((sum_i == {WIDTH{~cin_i}}) && (cout_i == cin_i)));
            for (int i = 0; i < WIDTH; i++) begin
                a_r3_implied_carry: assert ((h_i[i] & xmit_ext_i[i]) == carry_in_bits[i]);
            end
        end
    end
endmodule

bind ling_adder ling_adder_chk #(.WIDTH(WIDTH)) chk_i (
    .a_i        (op_a_i),
    .b_i        (op_b_i),
    .cin_i      (carry_in_i),
    .sum_i      (sum_o),
    .cout_i     (carry_out_o),
    .h_i        (h),
    .xmit_ext_i (xmit_ext)
);

// File: tb/ling_adder_tb_top.sv
module ling_adder_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;  // 200 MHz

    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    logic [15:0] a16, b16, s16;
    logic        c16, co16;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          big;
        logic [16:0] exp_total;
        logic [15:0] exp_carry;
        string       tag;
    } item_t;
    item_t q[$];

    ling_adder #(.WIDTH(8), .GROUP(3)) dut8_i (
        .op_a_i(a8), .op_b_i(b8), .carry_in_i(c8), .sum_o(s8), .carry_out_o(co8));
    ling_adder #(.WIDTH(16), .GROUP(4)) dut_i (
        .op_a_i(a16), .op_b_i(b16), .carry_in_i(c16), .sum_o(s16), .carry_out_o(co16));

    // Reference: bit-serial ripple, independent of the design's structure
    function automatic item_t model(input bit big, input logic [15:0] a,
                                    input logic [15:0] b, input logic cin,
                                    input int w, input string tag);
        item_t it;
        logic c;
        it.big = big; it.tag = tag; it.exp_total = '0; it.exp_carry = '0;
        c = cin;
        for (int i = 0; i < w; i++) begin
            it.exp_carry[i] = c;
            it.exp_total[i] = a[i] ^ b[i] ^ c;
            c = (a[i] & b[i]) | (c & (a[i] | b[i]));
        end
        it.exp_total[w] = c;
        return it;
    endfunction

    task automatic drive8(input logic [7:0] a, input logic [7:0] b,
                          input logic cin, input string tag);
        @(posedge clk); #1;
        a8 = a; b8 = b; c8 = cin;
        q.push_back(model(1'b0, {8'h0, a}, {8'h0, b}, cin, 8, tag));
    endtask

    task automatic drive16(input logic [15:0] a, input logic [15:0] b,
                           input logic cin, input string tag);
        @(posedge clk); #1;
        a16 = a; b16 = b; c16 = cin;
        q.push_back(model(1'b1, a, b, cin, 16, tag));
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: mid-period sampling; outputs must already show the vector (R8)
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [16:0] act;
            logic [15:0] act_c;
            it = q.pop_front();
            if (it.big) begin
                act   = {co16, s16};
                act_c = s16 ^ a16 ^ b16;
            end else begin
                act   = {8'h0, co8, s8};
                act_c = {8'h0, s8 ^ a8 ^ b8};
            end
            check(act == it.exp_total, it.tag, act, it.exp_total);
            check(act_c == it.exp_carry, "R3 carry into each bit",
                  {1'b0, act_c}, {1'b0, it.exp_carry});
        end
    end

    initial begin
        a8 = '0; b8 = '0; c8 = 1'b0; a16 = '0; b16 = '0; c16 = 1'b0;
        repeat (3) @(posedge clk);
        // R2: zero operands, both carry-in values
        drive16(16'h0000, 16'h0000, 1'b0, "R2 zero operands cin0");
        drive16(16'h0000, 16'h0000, 1'b1, "R2 zero operands cin1");
        // R5: full propagate patterns
        drive16(16'hFFFF, 16'h0000, 1'b1, "R5 propagate cin1");
        drive16(16'hFFFF, 16'h0000, 1'b0, "R5 propagate cin0");
        drive16(16'hA5C3, 16'h5A3C, 1'b1, "R5 mixed propagate cin1");
        // R6: full generate
        drive16(16'hFFFF, 16'hFFFF, 1'b0, "R6 generate cin0");
        drive16(16'hFFFF, 16'hFFFF, 1'b1, "R6 generate cin1");
        // R4: carry born at bit 0 ripples to carry-out
        drive16(16'h7FFF, 16'h8001, 1'b0, "R4 ripple to carry-out");
        drive16(16'h8000, 16'h8000, 1'b0, "R4 top generate");
        drive16(16'h8000, 16'h0000, 1'b1, "R4 no carry-out");
        // R7: exhaustive 8-bit with a short last group
        for (int ci = 0; ci < 2; ci++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    drive8(8'(a), 8'(b), 1'(ci), "R7 exhaustive 8-bit group3");
        // R1: pseudo-random 16-bit vectors
        for (int n = 0; n < 3000; n++)
            drive16(16'($urandom), 16'($urandom), 1'($urandom), "R1 random 16-bit");
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule